// File: doc/BRIEF.md
# Masked Truth-Table Fitness Scorer

This block scores how closely a candidate logic circuit reproduces a target truth table in which some entries are left unspecified. The table arrives as a stream of words. Each word holds `WORD_W` rows of a single output column, and the rows are compared in parallel. With each word the block receives three vectors. The first is the candidate's output bits. The second is the target bits. The third is a validity mask, in which a 1 marks an entry the target specifies and a 0 marks an entry the target leaves open. Open entries always count as correct. Specified entries count as correct only when the candidate bit equals the target bit. The per-word counts are added over the whole table. When the last word has been taken, the block reports the final score with a one-cycle done pulse. Along with the score it gives a flag that says whether every row position of every word was counted as correct.

A second scoring mode lets a search procedure decide, per open entry, how that entry is to be treated. A two-bit gene travels alongside each row. For an open entry the gene can pin the target to 0, pin it to 1, or leave the entry open. The effective target and mask are rebuilt from the genes on every word. Genes have no effect on entries the mask already specifies, and they are ignored altogether in the plain mode.

A run is opened by a start pulse, which clears the running total. Words may arrive with idle cycles between them. The final word is marked with a last flag.

Top module: `fit_scorer`

## Requirements
- R1: In plain mode (`mode_i`=0), each accepted word adds to the total the number of row positions k where either `mask_i[k]`=0, or `mask_i[k]`=1 and `act_i[k]`=`des_i[k]`.
- R2: Target bits at open positions (`mask_i[k]`=0) never change the score, whatever their value, in either mode unless a gene pins them.
- R3: In extended mode (`mode_i`=1), the gene of row k is `gene_i[2k+1:2k]`. For an open entry, code 00 makes the target 0 and specified, code 01 makes it 1 and specified, and codes 10 and 11 leave it open. The word is then scored as in R1 with the rewritten target and mask.
- R4: Genes have no effect at positions with `mask_i[k]`=1, and no effect at any position in plain mode.
- R5: A cycle with `start_i`=1 clears the running total and word count. If `word_valid_i` is also 1 in that cycle, that word is the first word of the new run.
- R6: Cycles with `word_valid_i`=0 leave the running total unchanged. Idle gaps between words do not alter the final score.
- R7: One cycle after a clock edge with `word_valid_i`=1 and `word_last_i`=1, `done_o` is 1 for exactly that cycle and `score_o` shows the run total. `score_o` and `perfect_o` then hold until the next done pulse.
- R8: `perfect_o`, updated together with `done_o`, is 1 exactly when the run total equals the number of words in the run times `WORD_W`.
- R9: After reset, `score_o`=0, `perfect_o`=0 and `done_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = plain mask scoring, 1 = gene-rewritten scoring |
| start_i | input | 1 | Clears the running total; opens a run |
| word_valid_i | input | 1 | A word is present this cycle |
| word_last_i | input | 1 | The present word closes the run |
| act_i | input | WORD_W | Candidate output bits for the rows of this word |
| des_i | input | WORD_W | Target output bits |
| mask_i | input | WORD_W | 1 = specified entry, 0 = open entry |
| gene_i | input | 2*WORD_W | Two-bit gene per row, row k at bits 2k+1:2k |
| score_o | output | SCORE_W | Final total of correct entries for the last run |
| perfect_o | output | 1 | Every position of the last run counted as correct |
| done_o | output | 1 | One-cycle pulse when score_o is updated |

## Verification
The hardest situation to reach from the ports is a start pulse that lands in the same cycle as a valid word, in the middle of a run. In that case the partial total must be discarded while the incoming word is kept. The bench opens a run, feeds two words and holds back the last flag. It then issues start together with a single closing word, and expects the score of that one word alone. Gene handling is reached by presenting words whose mask is fully open, fully specified and mixed. Each gene code is applied to all rows, so a misdecoded code moves the score by the full word width.

// File: rtl/fit_pkg.sv
package fit_pkg;

    typedef enum logic {
        MODE_PLAIN    = 1'b0,
        MODE_EXTENDED = 1'b1
    } fit_mode_e;

    localparam logic [1:0] GENE_PIN_ZERO = 2'b00;
    localparam logic [1:0] GENE_PIN_ONE  = 2'b01;

endpackage

// File: rtl/fit_gene_rewrite.sv
module fit_gene_rewrite #(
    parameter int WORD_W = 32
) (
    input  logic                  en_i,
    input  logic [WORD_W-1:0]     des_i,
    input  logic [WORD_W-1:0]     mask_i,
    input  logic [2*WORD_W-1:0]   gene_i,
    output logic [WORD_W-1:0]     des_o,
    output logic [WORD_W-1:0]     mask_o
);
    import fit_pkg::*;

    for (genvar k = 0; k < WORD_W; k++) begin : g_row
        logic [1:0] code;
        assign code = gene_i[2*k +: 2];

        always_comb begin
            des_o[k]  = des_i[k];
            mask_o[k] = mask_i[k];
            if (en_i && !mask_i[k]) begin
                if (code == GENE_PIN_ZERO) begin
                    des_o[k]  = 1'b0;
                    mask_o[k] = 1'b1;
                end else if (code == GENE_PIN_ONE) begin
                    des_o[k]  = 1'b1;
                    mask_o[k] = 1'b1;
                end
            end
        end

        // R4: a specified entry passes through untouched
        always_comb begin
            if (mask_i[k]) begin
                p_defined_kept_r4: assert (mask_o[k] && (des_o[k] == des_i[k]));
            end
        end
    end

endmodule

// File: rtl/fit_match.sv
module fit_match #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] act_i,
    input  logic [WORD_W-1:0] des_i,
    input  logic [WORD_W-1:0] mask_i,
    output logic [WORD_W-1:0] hit_o
);
    logic [WORD_W-1:0] act_m;
    logic [WORD_W-1:0] des_m;

    always_comb begin
        act_m = act_i & mask_i;
        des_m = des_i & mask_i;
        hit_o = ~(act_m ^ des_m);
    end

    // R1: a mismatch can only be reported at a specified entry
    always_comb begin
        p_open_hit_r1: assert ((~hit_o & ~mask_i) == '0);
    end

endmodule

// File: rtl/fit_popcount.sv
module fit_popcount #(
    parameter int WORD_W = 32,
    localparam int CNT_W = $clog2(WORD_W + 1)
) (
    input  logic [WORD_W-1:0] bits_i,
    output logic [CNT_W-1:0]  count_o
);
    localparam int LEAVES = 1 << $clog2(WORD_W);
    localparam int LEVELS = $clog2(LEAVES);

    logic [CNT_W-1:0] node [LEVELS+1][LEAVES];

    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < WORD_W) begin : g_real
            assign node[0][i] = CNT_W'(bits_i[i]);
        end else begin : g_pad
            assign node[0][i] = '0;
        end
    end

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        for (genvar j = 0; j < LEAVES; j++) begin : g_node
            if (j < (LEAVES >> (l + 1))) begin : g_add
                assign node[l+1][j] = node[l][2*j] + node[l][2*j+1];
            end else begin : g_zero
                assign node[l+1][j] = '0;
            end
        end
    end

    assign count_o = node[LEVELS][0];

endmodule

// File: rtl/fit_scorer.sv
module fit_scorer #(
    parameter int WORD_W    = 32,
    parameter int MAX_WORDS = 1024,
    localparam int POP_W    = $clog2(WORD_W + 1),
    localparam int WCNT_W   = $clog2(MAX_WORDS + 1),
    localparam int SCORE_W  = $clog2(MAX_WORDS * WORD_W + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_i,
    input  logic                 start_i,
    input  logic                 word_valid_i,
    input  logic                 word_last_i,
    input  logic [WORD_W-1:0]    act_i,
    input  logic [WORD_W-1:0]    des_i,
    input  logic [WORD_W-1:0]    mask_i,
    input  logic [2*WORD_W-1:0]  gene_i,
    output logic [SCORE_W-1:0]   score_o,
    output logic                 perfect_o,
    output logic                 done_o
);
    import fit_pkg::*;

    typedef struct packed {
        logic [SCORE_W-1:0] acc;
        logic [WCNT_W-1:0]  words;
        logic [SCORE_W-1:0] score;
        logic               perfect;
        logic               done;
    } state_t;

    state_t state_d, state_q;

    fit_mode_e         mode;
    logic [WORD_W-1:0] des_eff;
    logic [WORD_W-1:0] mask_eff;
    logic [WORD_W-1:0] hit;
    logic [POP_W-1:0]  word_score;

    assign mode = fit_mode_e'(mode_i);

    fit_gene_rewrite #(.WORD_W(WORD_W)) u_rewrite (
        .en_i   (mode == MODE_EXTENDED),
        .des_i  (des_i),
        .mask_i (mask_i),
        .gene_i (gene_i),
        .des_o  (des_eff),
        .mask_o (mask_eff)
    );

    fit_match #(.WORD_W(WORD_W)) u_match (
        .act_i  (act_i),
        .des_i  (des_eff),
        .mask_i (mask_eff),
        .hit_o  (hit)
    );

    fit_popcount #(.WORD_W(WORD_W)) u_pop (
        .bits_i  (bits_in_pop()),
        .count_o (word_score)
    );

    function automatic logic [WORD_W-1:0] bits_in_pop();
        return hit;
    endfunction

    always_comb begin
        logic [SCORE_W-1:0] acc_base;
        logic [WCNT_W-1:0]  words_base;
        logic [SCORE_W-1:0] full;

        state_d      = state_q;
        state_d.done = 1'b0;
        acc_base     = start_i ? '0 : state_q.acc;
        words_base   = start_i ? '0 : state_q.words;
        state_d.acc   = acc_base;
        state_d.words = words_base;
        full          = '0;

        if (word_valid_i) begin
            state_d.acc   = acc_base + SCORE_W'(word_score);
            state_d.words = words_base + 1'b1;
            if (word_last_i) begin
                full            = SCORE_W'(state_d.words) * SCORE_W'(WORD_W);
                state_d.score   = state_d.acc;
                state_d.perfect = (state_d.acc == full);
                state_d.done    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign score_o   = state_q.score;
    assign perfect_o = state_q.perfect;
    assign done_o    = state_q.done;

    // R5: a lone start empties the running total
    p_start_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !word_valid_i) |=> (state_q.acc == '0));

    // R6: idle cycles leave the total alone
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !word_valid_i) |=> $stable(state_q.acc));

    // R7: done follows a closing word
    p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid_i && word_last_i) |=> done_o);

    // R7: no done and a steady result without a closing word
    p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_valid_i && word_last_i) |=> (!done_o && $stable(score_o) && $stable(perfect_o)));

    // R8: the total never exceeds the words taken times the word width
    p_total_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.acc <= SCORE_W'(state_q.words) * SCORE_W'(WORD_W)));

endmodule

// File: tb/fit_scorer_bench.sv
module fit_scorer_bench;
    localparam int W  = 32;
    localparam int SW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_i = 1'b0;
    logic          start_i = 1'b0;
    logic          word_valid_i = 1'b0;
    logic          word_last_i = 1'b0;
    logic [W-1:0]  act_i = '0;
    logic [W-1:0]  des_i = '0;
    logic [W-1:0]  mask_i = '0;
    logic [2*W-1:0] gene_i = '0;
    logic [SW-1:0] score_o;
    logic          perfect_o;
    logic          done_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    fit_scorer u_fit_scorer (
        .clk, .rst_n, .mode_i, .start_i, .word_valid_i, .word_last_i,
        .act_i, .des_i, .mask_i, .gene_i, .score_o, .perfect_o, .done_o
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int model_word(input logic [W-1:0] a, input logic [W-1:0] d,
                                      input logic [W-1:0] m, input logic [2*W-1:0] g,
                                      input logic md);
        int s = 0;
        for (int k = 0; k < W; k++) begin
            logic dm = m[k];
            logic dd = d[k];
            if (md && !m[k]) begin
                if (g[2*k +: 2] == 2'b00) begin dm = 1; dd = 0; end
                else if (g[2*k +: 2] == 2'b01) begin dm = 1; dd = 1; end
            end
            if (!dm || (a[k] == dd)) s++;
        end
        return s;
    endfunction

    // drive one word at a falling edge; returns after the next falling edge
    task automatic send(input bit st, input logic [W-1:0] a, input logic [W-1:0] d,
                        input logic [W-1:0] m, input logic [2*W-1:0] g, input bit last);
        start_i = st; word_valid_i = 1; word_last_i = last;
        act_i = a; des_i = d; mask_i = m; gene_i = g;
        @(negedge clk);
        start_i = 0; word_valid_i = 0; word_last_i = 0;
    endtask

    function automatic logic [2*W-1:0] all_genes(input logic [1:0] c);
        return {W{c}};
    endfunction

    task automatic score_one(input logic md, input logic [W-1:0] a, input logic [W-1:0] d,
                             input logic [W-1:0] m, input logic [2*W-1:0] g,
                             input int exp, input string tag);
        mode_i = md;
        send(1, a, d, m, g, 1);
        check(done_o == 1, {tag, " done"}, done_o, 1);
        check(score_o == SW'(exp), tag, score_o, exp);
        check(perfect_o == (exp == W), {tag, " perfect"}, perfect_o, exp == W);
    endtask

    task automatic t_reset();
        check(score_o == 0, "R9 score", score_o, 0);
        check(perfect_o == 0, "R9 perfect", perfect_o, 0);
        check(done_o == 0, "R9 done", done_o, 0);
    endtask

    task automatic t_plain();
        score_one(0, 32'hA5A5_1234, 32'hA5A5_1234, '1, '0, 32, "R1 exact");
        // differ everywhere, half specified -> 16 open hits
        score_one(0, 32'hFFFF_0000, 32'h0000_FFFF, 32'hFF00_FF00, '0, 16, "R1 half");
        score_one(0, 32'h0000_0000, 32'hFFFF_FFFF, '1, '0, 0, "R1 none");
        score_one(0, 32'h0F0F_00FF, 32'h0FF0_0F0F, 32'h3C3C_C3C3,
                  '0, model_word(32'h0F0F_00FF, 32'h0FF0_0F0F, 32'h3C3C_C3C3, '0, 0), "R1 mixed");
    endtask

    task automatic t_open_target();
        // only open positions of des differ between the two runs
        score_one(0, 32'h1357_9BDF, 32'h0000_0000, 32'h00FF_00FF,
                  '0, model_word(32'h1357_9BDF, 0, 32'h00FF_00FF, '0, 0), "R2 des0");
        score_one(0, 32'h1357_9BDF, 32'hFF00_FF00, 32'h00FF_00FF,
                  '0, model_word(32'h1357_9BDF, 0, 32'h00FF_00FF, '0, 0), "R2 des1");
        score_one(1, 32'h1357_9BDF, 32'hFF00_FF00, 32'h00FF_00FF, all_genes(2'b10),
                  model_word(32'h1357_9BDF, 0, 32'h00FF_00FF, '0, 0), "R2 ext open");
    endtask

    task automatic t_genes();
        score_one(1, '0, '0, '0, all_genes(2'b01), 0,  "R3 pin one");
        score_one(1, '0, '1, '0, all_genes(2'b00), 32, "R3 pin zero");
        score_one(1, '1, '0, '0, all_genes(2'b00), 0,  "R3 pin zero vs ones");
        score_one(1, '0, '1, '0, all_genes(2'b10), 32, "R3 code 10 open");
        score_one(1, '0, '1, '0, all_genes(2'b11), 32, "R3 code 11 open");
        score_one(1, 32'hCAFE_0001, 32'h1234_5678, 32'hF0F0_0FF0, 64'h1B1B_E4E4_0123_CDEF,
                  model_word(32'hCAFE_0001, 32'h1234_5678, 32'hF0F0_0FF0, 64'h1B1B_E4E4_0123_CDEF, 1),
                  "R3 mixed");
    endtask

    task automatic t_gene_ignored();
        score_one(1, '0, '0, '1, all_genes(2'b01), 32, "R4 defined kept");
        score_one(0, '0, '1, '0, all_genes(2'b01), 32, "R4 plain ignores");
        score_one(0, 32'h00FF_FF00, 32'h0F0F_0F0F, 32'h33CC_33CC, all_genes(2'b00),
                  model_word(32'h00FF_FF00, 32'h0F0F_0F0F, 32'h33CC_33CC, '0, 0), "R4 plain genes");
    endtask

    task automatic t_multi();
        logic [SW-1:0] held;
        mode_i = 0;
        send(1, 32'h1111_1111, 32'h1111_1111, '1, '0, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); @(negedge clk);
            send(0, 32'h1111_1111, 32'h1111_1111, '1, '0, i == 2);
        end
        check(score_o == 128, "R6 gaps total", score_o, 128);
        check(perfect_o == 1, "R8 perfect run", perfect_o, 1);
        @(negedge clk);
        check(done_o == 0, "R7 single pulse", done_o, 1'b0);
        held = score_o;
        send(1, 32'h0000_0001, 32'h0000_0000, '1, '0, 0);
        @(negedge clk);
        check(score_o == held, "R7 held mid run", score_o, held);
        send(0, '0, '0, '1, '0, 0);
        send(0, '0, '0, '1, '0, 1);
        check(score_o == 95, "R5 three word total", score_o, 95);
        check(perfect_o == 0, "R8 not perfect", perfect_o, 0);
    endtask

    task automatic t_restart();
        mode_i = 0;
        send(1, '0, '0, '1, '0, 0);
        send(0, '0, '0, '1, '0, 0);
        // restart carried on a word that also closes the run
        send(1, 32'h0000_00FF, '0, '1, '0, 1);
        check(score_o == 24, "R5 start with word", score_o, 24);
        check(perfect_o == 0, "R8 restart perfect", perfect_o, 0);
        send(1, 32'h0, '0, '1, '0, 1);
        check(perfect_o == 1, "R8 restart one word", perfect_o, 1);
    endtask

    task automatic t_sweep();
        logic [31:0] lf = 32'hACE1_2468;
        for (int r = 0; r < 20; r++) begin
            logic [W-1:0] a, d, m;
            logic [2*W-1:0] g;
            int exp = 0;
            int nw = 1 + (r % 4);
            mode_i = r[0];
            for (int w = 0; w < nw; w++) begin
                lf = lf * 32'd1664525 + 32'd1013904223; a = lf;
                lf = lf * 32'd1664525 + 32'd1013904223; d = lf;
                lf = lf * 32'd1664525 + 32'd1013904223; m = lf;
                lf = lf * 32'd1664525 + 32'd1013904223; g[31:0] = lf;
                lf = lf * 32'd1664525 + 32'd1013904223; g[63:32] = lf;
                exp += model_word(a, d, m, g, mode_i);
                send(w == 0, a, d, m, g, w == nw - 1);
            end
            check(score_o == SW'(exp), r[0] ? "R3 sweep" : "R1 sweep", score_o, exp);
            check(perfect_o == (exp == nw * W), "R8 sweep", perfect_o, exp == nw * W);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_open_target();
        t_genes();
        t_gene_ignored();
        t_multi();
        t_restart();
        t_sweep();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule